// File: doc/BRIEF.md
# Byte-Serial Register Write Decoder

This block turns a narrow byte-wide command stream into register write strobes. A command begins with a strobe that accompanies its first byte. That byte is the low half of an address and the next byte is the high half. Zero, one, two or four data bytes follow on consecutive cycles. The block keeps the low address bits and checks them against a fixed window, given as a base value and a mask. When the address falls inside the window, the block raises a one-cycle write enable. With it, it presents the address bits that the mask leaves free and the assembled data word. Several instances with different windows and widths can listen to the same stream, and each one picks out its own registers.

The data width is chosen at elaboration: 0, 8, 16 or 32 bits. In the zero-width form a command carries no data bytes, and the written value is the address LSB. Two neighbouring addresses therefore form a clear/set pair for one control bit.

The sequencer has three states. `ST_IDLE` waits for a strobe and takes the transition *start* to `ST_ADDR_HI`. From `ST_ADDR_HI` a byte without a strobe takes one of two transitions. With data bytes configured it takes *to_data* into `ST_DATA` with the byte index at zero. With no data bytes it takes *done* back to `ST_IDLE`. In `ST_DATA` the index advances on each byte (*next_byte*) until the last byte, which takes *done* to `ST_IDLE`. From `ST_ADDR_HI` or `ST_DATA`, a strobe takes *restart* to `ST_ADDR_HI`. In `ST_IDLE` a byte without a strobe takes *stay* and is ignored.

Top module: `serial_cmd_decoder`

## Requirements
- R1: While reset is held, and on the first cycle after it, `wr_en`, `wr_offset` and `wr_data` are all zero.
- R2: A command is the strobed byte (address bits 7:0), then the next unstrobed byte (address bits 15:8), then DATA_BITS/8 data bytes on consecutive cycles. Only address bits ADDR_BITS-1:0 are used, and the higher bits of the second byte have no effect.
- R3: A command is accepted exactly when (address & MASK) == (BASE & MASK).
- R4: An accepted command raises `wr_en` for exactly one cycle. That cycle is the one right after the cycle that carried the command's final byte.
- R5: On acceptance, `wr_offset` equals address & ~MASK over ADDR_BITS bits.
- R6: With a nonzero width, data is assembled little-endian: the first data byte lands in `wr_data[7:0]` and the k-th data byte in bits 8k+7:8k.
- R7: With DATA_BITS = 0, `wr_data` is one bit equal to address bit 0. An odd address writes 1 and an even address writes 0.
- R8: A strobe in the middle of a command discards the partial command and starts a new one with that byte as the address low byte.
- R9: A command outside the window gives no pulse, and `wr_offset` and `wr_data` keep their previous values.
- R10: Bytes that arrive without a strobe while no command is in progress cause no pulse and change no output.
- R11: The strobe of a new command may come on the cycle right after the previous command's final byte, and both commands are decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_ad | input | 8 | Command byte stream (address low, address high, data bytes) |
| cmd_stb | input | 1 | High with the first byte of a command only |
| wr_en | output | 1 | One-cycle write pulse for an accepted command |
| wr_offset | output | ADDR_BITS | Address bits outside the mask, held between pulses |
| wr_data | output | DW (DATA_BITS, or 1 when DATA_BITS is 0) | Assembled data word, held between pulses |

## Verification
The hardest situations to reach from the ports are those where framing and timing interact. One is a strobe that cuts into a command while it is still in `ST_ADDR_HI` or `ST_DATA`. Another is a new strobe that lands on the very cycle the previous command's pulse is due. A third is a non-matching command, which must leave the held outputs untouched. Directed sequences drive truncated commands and then a full command, placing the restart on the high-address slot and on a data slot. A random phase sends commands with no idle gap, or with one or two stray unstrobed bytes between them. Half of its addresses are forced into the window and the rest are unconstrained, with random upper address bits. A zero-width instance gets the same treatment, with odd and even addresses.

// File: rtl/sercmd_pkg.sv
package sercmd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ADDR_HI = 2'd1,
        ST_DATA    = 2'd2
    } state_e;

    // number of data bytes that follow the two address bytes
    function automatic int data_bytes(input int bits);
        return bits / 8;
    endfunction

    // width of the data output; the zero-width form still drives one bit
    function automatic int data_width(input int bits);
        return (bits == 0) ? 1 : bits;
    endfunction

endpackage

// File: rtl/sercmd_fsm.sv
module sercmd_fsm
    import sercmd_pkg::*;
#(
    parameter int NBYTES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       stb,
    output state_e     state_o,
    output logic [1:0] idx_o,
    output logic       ld_ah,
    output logic       ld_d,
    output logic       finish
);

    localparam int         LAST     = (NBYTES == 0) ? 0 : NBYTES - 1;
    localparam logic [1:0] LAST_IDX = 2'(LAST);
    localparam logic       NO_DATA  = (NBYTES == 0);

    state_e     state_q, state_d;
    logic [1:0] idx_q, idx_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (stb) state_d = ST_ADDR_HI;          // start
            end
            ST_ADDR_HI: begin
                if (stb) begin
                    state_d = ST_ADDR_HI;               // restart
                end else if (NO_DATA) begin
                    state_d = ST_IDLE;                  // done
                end else begin
                    state_d = ST_DATA;                  // to_data
                    idx_d   = '0;
                end
            end
            ST_DATA: begin
                if (stb) begin
                    state_d = ST_ADDR_HI;               // restart
                end else if (idx_q == LAST_IDX) begin
                    state_d = ST_IDLE;                  // done
                end else begin
                    idx_d = idx_q + 2'd1;               // next_byte
                end
            end
            default: begin
                state_d = ST_IDLE;
                idx_d   = '0;
            end
        endcase
    end

    // per-byte controls
    always_comb begin
        ld_ah  = (state_q == ST_ADDR_HI) && !stb;
        ld_d   = (state_q == ST_DATA) && !stb;
        finish = !stb &&
                 (((state_q == ST_ADDR_HI) && NO_DATA) ||
                  ((state_q == ST_DATA) && (idx_q == LAST_IDX)));
    end

    assign state_o = state_q;
    assign idx_o   = idx_q;

endmodule

// File: rtl/sercmd_capture.sv
module sercmd_capture #(
    parameter int ADDR_BITS = 11,
    parameter int NBYTES    = 2,
    parameter int DW        = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [7:0]           byte_i,
    input  logic                 ld_al,
    input  logic                 ld_ah,
    input  logic                 ld_d,
    input  logic [1:0]           idx,
    output logic [ADDR_BITS-1:0] addr_o,
    output logic [DW-1:0]        data_o
);

    localparam int HI_BITS = ADDR_BITS - 8;

    logic [7:0] al_q;

    always_ff @(posedge clk) begin
        if (rst)        al_q <= '0;
        else if (ld_al) al_q <= byte_i;
    end

    generate
        if (NBYTES == 0) begin : g_bitcmd
            // final byte is the address high byte itself, taken from the port
            assign addr_o    = {byte_i[HI_BITS-1:0], al_q};
            assign data_o[0] = addr_o[0];
        end else begin : g_wordcmd
            logic [HI_BITS-1:0] ah_q;

            always_ff @(posedge clk) begin
                if (rst)        ah_q <= '0;
                else if (ld_ah) ah_q <= byte_i[HI_BITS-1:0];
            end

            assign addr_o = {ah_q, al_q};

            for (genvar i = 0; i < NBYTES; i++) begin : g_byte
                if (i == NBYTES - 1) begin : g_last
                    assign data_o[8*i +: 8] = byte_i;
                end else begin : g_held
                    logic [7:0] q;
                    always_ff @(posedge clk) begin
                        if (rst)                         q <= '0;
                        else if (ld_d && idx == 2'(i))   q <= byte_i;
                    end
                    assign data_o[8*i +: 8] = q;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/sercmd_window.sv
module sercmd_window #(
    parameter int          ADDR_BITS = 11,
    parameter int unsigned BASE      = 'h050,
    parameter int unsigned MASK      = 'h7f8
) (
    input  logic [ADDR_BITS-1:0] addr,
    output logic                 hit,
    output logic [ADDR_BITS-1:0] offset
);

    localparam logic [ADDR_BITS-1:0] M = ADDR_BITS'(MASK);
    localparam logic [ADDR_BITS-1:0] B = ADDR_BITS'(BASE) & M;

    always_comb begin
        hit    = ((addr & M) == B);
        offset = addr & ~M;
    end

endmodule

// File: rtl/serial_cmd_decoder.sv
module serial_cmd_decoder
    import sercmd_pkg::*;
#(
    parameter int          ADDR_BITS = 11,
    parameter int unsigned BASE      = 'h050,
    parameter int unsigned MASK      = 'h7f8,
    parameter int          DATA_BITS = 16,
    localparam int         DW        = data_width(DATA_BITS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [7:0]           cmd_ad,
    input  logic                 cmd_stb,
    output logic                 wr_en,
    output logic [ADDR_BITS-1:0] wr_offset,
    output logic [DW-1:0]        wr_data
);

    localparam int NBYTES = data_bytes(DATA_BITS);

    state_e               seq_state;
    logic [1:0]           seq_idx;
    logic                 ld_ah, ld_d, finish;
    logic [ADDR_BITS-1:0] cmd_addr, win_offset;
    logic [DW-1:0]        cmd_data;
    logic                 win_hit;

    sercmd_fsm #(
        .NBYTES (NBYTES)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .stb     (cmd_stb),
        .state_o (seq_state),
        .idx_o   (seq_idx),
        .ld_ah   (ld_ah),
        .ld_d    (ld_d),
        .finish  (finish)
    );

    sercmd_capture #(
        .ADDR_BITS (ADDR_BITS),
        .NBYTES    (NBYTES),
        .DW        (DW)
    ) u_cap (
        .clk    (clk),
        .rst    (rst),
        .byte_i (cmd_ad),
        .ld_al  (cmd_stb),
        .ld_ah  (ld_ah),
        .ld_d   (ld_d),
        .idx    (seq_idx),
        .addr_o (cmd_addr),
        .data_o (cmd_data)
    );

    sercmd_window #(
        .ADDR_BITS (ADDR_BITS),
        .BASE      (BASE),
        .MASK      (MASK)
    ) u_win (
        .addr   (cmd_addr),
        .hit    (win_hit),
        .offset (win_offset)
    );

    // outputs: pulse plus held offset/data
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en     <= 1'b0;
            wr_offset <= '0;
            wr_data   <= '0;
        end else begin
            wr_en <= finish && win_hit;
            if (finish && win_hit) begin
                wr_offset <= win_offset;
                wr_data   <= cmd_data;
            end
        end
    end

endmodule

// File: rtl/sercmd_checks.sv
module sercmd_checks #(
    parameter int          ADDR_BITS = 11,
    parameter int unsigned MASK      = 'h7f8,
    parameter int          DW        = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cmd_stb,
    input logic                 wr_en,
    input logic [ADDR_BITS-1:0] wr_offset,
    input logic [DW-1:0]        wr_data
);

    localparam logic [ADDR_BITS-1:0] M = ADDR_BITS'(MASK);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!wr_en && wr_offset == '0 && wr_data == '0));

    p_single_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    p_pulse_after_unstrobed_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !$past(cmd_stb));

    p_offset_in_window_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_offset & M) == '0);

    p_hold_outputs_r9: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> ($stable(wr_offset) && $stable(wr_data)));

endmodule

bind serial_cmd_decoder sercmd_checks #(
    .ADDR_BITS (ADDR_BITS),
    .MASK      (MASK),
    .DW        (DW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_stb   (cmd_stb),
    .wr_en     (wr_en),
    .wr_offset (wr_offset),
    .wr_data   (wr_data)
);

// File: tb/serial_cmd_decoder_tb.sv
module serial_cmd_decoder_tb;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    // 16-bit instance: base 0x050, mask 0x7f8
    logic [7:0]  ad16 = '0;
    logic        stb16 = 1'b0;
    logic        w16_en;
    logic [10:0] w16_off;
    logic [15:0] w16_data;

    // zero-width instance: base 0x020, mask 0x7f0
    logic [7:0]  ad0 = '0;
    logic        stb0 = 1'b0;
    logic        w0_en;
    logic [10:0] w0_off;
    logic [0:0]  w0_data;

    serial_cmd_decoder #(.ADDR_BITS(11), .BASE('h050), .MASK('h7f8), .DATA_BITS(16)) u_dut (
        .clk(clk), .rst(rst), .cmd_ad(ad16), .cmd_stb(stb16),
        .wr_en(w16_en), .wr_offset(w16_off), .wr_data(w16_data));

    serial_cmd_decoder #(.ADDR_BITS(11), .BASE('h020), .MASK('h7f0), .DATA_BITS(0)) u_dz (
        .clk(clk), .rst(rst), .cmd_ad(ad0), .cmd_stb(stb0),
        .wr_en(w0_en), .wr_offset(w0_off), .wr_data(w0_data));

    int n_checks = 0;
    int n_fail   = 0;

    logic [10:0] h16_off  = '0;
    logic [15:0] h16_data = '0;
    logic [10:0] h0_off   = '0;
    logic        h0_data  = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic hit16(input logic [15:0] a);
        return (a[10:0] & 11'h7f8) == 11'h050;
    endfunction

    function automatic logic hit0(input logic [15:0] a);
        return (a[10:0] & 11'h7f0) == 11'h020;
    endfunction

    task automatic step16(input logic s, input logic [7:0] b);
        stb16 = s; ad16 = b;
        @(negedge clk);
    endtask

    task automatic step0(input logic s, input logic [7:0] b);
        stb0 = s; ad0 = b;
        @(negedge clk);
    endtask

    // R2/R3/R4/R5/R6/R9: full command, checked in the cycle after its last byte
    task automatic cmd16(input logic [15:0] a, input logic [15:0] d, input string tag);
        logic h;
        step16(1'b1, a[7:0]);
        step16(1'b0, a[15:8]);
        step16(1'b0, d[7:0]);
        step16(1'b0, d[15:8]);
        h = hit16(a);
        if (h) begin
            h16_off  = a[10:0] & 11'h007;
            h16_data = d;
        end
        check({tag, " R4 pulse"}, 32'(w16_en), 32'(h));
        check({tag, " R5 offset"}, 32'(w16_off), 32'(h16_off));
        check({tag, " R6 data"}, 32'(w16_data), 32'(h16_data));
    endtask

    // R7: zero-width command
    task automatic cmd0(input logic [15:0] a, input string tag);
        logic h;
        step0(1'b1, a[7:0]);
        step0(1'b0, a[15:8]);
        h = hit0(a);
        if (h) begin
            h0_off  = a[10:0] & 11'h00f;
            h0_data = a[0];
        end
        check({tag, " R4 pulse"}, 32'(w0_en), 32'(h));
        check({tag, " R5 offset"}, 32'(w0_off), 32'(h0_off));
        check({tag, " R7 bit"}, 32'(w0_data), 32'(h0_data));
    endtask

    initial begin
        repeat (CLK_PERIOD * 20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] a;
        logic [15:0] d;
        void'($urandom(32'd7331));

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 en16", 32'(w16_en), 0);
        check("R1 off16", 32'(w16_off), 0);
        check("R1 data16", 32'(w16_data), 0);
        check("R1 en0", 32'(w0_en), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release", 32'(w16_en), 0);

        // R2/R6: basic hit and byte order
        cmd16(16'h0053, 16'hBEEF, "R2 basic");
        step16(1'b0, 8'hA5);
        check("R4 one cycle", 32'(w16_en), 0);

        // R2: upper address bits ignored
        cmd16(16'hF857, 16'h0102, "R2 high bits");
        step16(1'b0, 8'h00);

        // R3/R9: misses leave outputs unchanged
        cmd16(16'h0060, 16'h1234, "R9 miss");
        cmd16(16'h0048, 16'h5555, "R3 below");
        cmd16(16'h0058, 16'h6666, "R3 above");
        cmd16(16'h0050, 16'hC001, "R3 low edge");
        cmd16(16'h0057, 16'hC0DE, "R3 high edge");

        // R10: stray unstrobed bytes while idle
        for (int i = 0; i < 6; i++) begin
            step16(1'b0, 8'(32'h51 + i));
            check("R10 stray pulse", 32'(w16_en), 0);
        end
        check("R10 stray offset", 32'(w16_off), 32'(h16_off));
        check("R10 stray data", 32'(w16_data), 32'(h16_data));

        // R8: restart at a data slot
        step16(1'b1, 8'h51);
        step16(1'b0, 8'h00);
        step16(1'b0, 8'h11);
        check("R8 partial no pulse", 32'(w16_en), 0);
        cmd16(16'h0052, 16'h7777, "R8 restart data");
        // R8: restart at the high-address slot
        step16(1'b1, 8'h54);
        cmd16(16'h0055, 16'h2468, "R8 restart hi");

        // R11: back-to-back
        cmd16(16'h0051, 16'hAAAA, "R11 first");
        cmd16(16'h0056, 16'h5A5A, "R11 second");
        step16(1'b0, 8'h00);

        // R7: zero-width directed
        cmd0(16'h0021, "R7 odd");
        cmd0(16'h0026, "R7 even");
        cmd0(16'h0031, "R9 zero miss");
        cmd0(16'hF82F, "R2 zero high bits");
        step0(1'b1, 8'h23);
        check("R8 zero partial", 32'(w0_en), 0);
        cmd0(16'h0024, "R8 zero restart");
        step0(1'b0, 8'h00);
        check("R4 zero one cycle", 32'(w0_en), 0);

        // random phase, 16-bit instance
        for (int n = 0; n < 300; n++) begin
            a = 16'($urandom);
            d = 16'($urandom);
            if ($urandom % 2 == 0) a[10:3] = 8'h0A;
            cmd16(a, d, "rand16");
            for (int g = 0; g < int'($urandom % 3); g++) begin
                step16(1'b0, 8'($urandom));
                check("R10 rand gap", 32'(w16_en), 0);
            end
        end

        // random phase, zero-width instance
        for (int n = 0; n < 300; n++) begin
            a = 16'($urandom);
            if ($urandom % 2 == 0) a[10:4] = 7'h02;
            cmd0(a, "rand0");
            for (int g = 0; g < int'($urandom % 3); g++) begin
                step0(1'b0, 8'($urandom));
                check("R10 rand0 gap", 32'(w0_en), 0);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule